// File: doc/BRIEF.md
# Event Timer Main Counter Register File

This block is the shared register front end of a multi-channel event timer. It answers 32-bit requests on a simple request/response bus. It holds a read-only capability word, the global configuration (a run enable and a legacy routing flag), the channel interrupt status word and the 64-bit main counter. The main counter advances on qualified ticks while the timer runs, and it freezes with its value kept while the timer is stopped.

Accesses to the per-channel register windows are decoded into a one-hot write strobe, a word offset and the write data for the addressed channel. Read data for those windows comes back from the channels. The block also sends the channels arm pulses when the timer starts, disarm pulses when it stops, and clear strobes when software acknowledges a status bit. The channels, their comparators and the interrupt routing sit outside this block.

Top module: `tmr_regblk`

## Requirements
- R1: Every request cycle (req_valid_i high) is answered with rsp_valid_o high exactly one cycle later. For a read, rsp_rdata_o carries the register value sampled at the request edge. A cycle with no request gives rsp_valid_o low in the next cycle.
- R2: Word 0x000 reads 0x8086A001 with (NCH-1) ORed into bits 12:8. Word 0x004 reads the tick period PERIOD_FS in femtoseconds. Writes to either word change nothing.
- R3: Word 0x010 is the global configuration: bit 0 is the run enable (enable_o) and bit 1 is the legacy flag (legacy_o). All other bits read zero and ignore writes. Word 0x014 reads zero.
- R4: The 64-bit counter (counter_o) increments by one at each edge where the enable is set and tick_i is high, carrying from the low half into the high half. Word 0x0F0 reads the low half and 0x0F4 reads the high half.
- R5: While the enable is clear, the counter holds its value whatever tick_i does, and it resumes from that value when the enable is set again. Either half can be written at any time, and a write takes priority over an increment in the same cycle.
- R6: Word 0x020 holds one status bit per channel in bits NCH-1:0. Bit i is set by sts_set_i[i] only while the enable is set; set pulses while stopped are ignored.
- R7: A write to 0x020 clears exactly those status bits that are written as one and are currently set. In the following cycle, sts_clr_o pulses those same bits.
- R8: When a config write sets the enable from zero to one, ch_arm_o pulses for one cycle (the first cycle with enable_o high). The pulse covers each channel whose ch_cmp_max_i was low at the write. ch_arm_o is zero at all other times.
- R9: When a config write clears the enable, ch_disarm_o pulses all ones in the next cycle. All status bits clear, and sts_clr_o pulses the bits that were set.
- R10: Words 0x100 to 0x3FF form channel windows with a stride of 0x20 (channel = (addr-0x100)/0x20). For a channel below NCH, a write asserts only that channel's ch_wr_o bit during the request cycle, with ch_off_o = addr[4:0] and ch_wdata_o = write data. A read returns ch_rdata_i for that channel. Windows at or above NCH read zero and assert no strobe.
- R11: Undefined or unaligned addresses read zero, and writes to them have no effect.
- R12: An active-low reset clears the counter, configuration and status, and drives all pulse outputs and rsp_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 10 | Byte address of the 32-bit word |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | 32 | Read data |
| tick_i | input | 1 | Counter tick qualifier |
| sts_set_i | input | NCH | Per-channel status set pulses |
| ch_cmp_max_i | input | NCH | Channel comparator is all ones |
| ch_rdata_i | input | NCH*32 | Per-channel read data for ch_off_o |
| counter_o | output | 64 | Main counter value |
| enable_o | output | 1 | Global run enable |
| legacy_o | output | 1 | Legacy routing flag |
| ch_wr_o | output | NCH | One-hot channel write strobe |
| ch_off_o | output | 5 | Word offset within the channel window |
| ch_wdata_o | output | 32 | Channel write data |
| sts_clr_o | output | NCH | Status clear strobes to channels |
| ch_arm_o | output | NCH | Arm pulses on enable rising |
| ch_disarm_o | output | NCH | Disarm pulses on enable falling |

## Verification
The bench uses NCH=3 and a period of 10,000,000 fs. With three channels, the read sweep covers every aligned word of the 1 KiB space: each fixed register, each in-range window and all 21 empty windows. Expected values are derived from arithmetic on the address. The bench also writes the first word of every one of the 24 window slots and checks the strobe pattern. Presetting the counter to 0x1_FFFFFFFF puts the low-to-high carry within a few ticks. A three-bit comparator-flag input makes mixed arm masks easy to build.

// File: rtl/tmr_regblk_pkg.sv
package tmr_regblk_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned CH_SLOT0 = 8;      // first 32-byte slot of channel space
  localparam int unsigned CH_FIELD_LSB = 8;  // channel-count field in capability
  localparam logic [31:0] CAP_BASE = 32'h8086_A001;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_STS    = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;

  typedef enum logic [2:0] {
    REG_NONE, REG_CAP_LO, REG_CAP_HI, REG_CFG,
    REG_STS, REG_CNT_LO, REG_CNT_HI, REG_CHAN
  } reg_sel_e;

  function automatic logic [31:0] cap_low(int unsigned nch);
    return CAP_BASE | (32'(nch - 1) << CH_FIELD_LSB);
  endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_regblk_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [4:0]        ch_idx_o
);
  logic [4:0] slot;
  assign slot     = addr_i[9:5];
  assign ch_idx_o = slot - 5'(CH_SLOT0);

  always_comb begin
    sel_o = REG_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (int'(slot) >= int'(CH_SLOT0)) begin
        if (int'(ch_idx_o) < int'(NCH)) sel_o = REG_CHAN;
      end else begin
        unique case (addr_i)
          OFF_CAP_LO: sel_o = REG_CAP_LO;
          OFF_CAP_HI: sel_o = REG_CAP_HI;
          OFF_CFG:    sel_o = REG_CFG;
          OFF_STS:    sel_o = REG_STS;
          OFF_CNT_LO: sel_o = REG_CNT_LO;
          OFF_CNT_HI: sel_o = REG_CNT_HI;
          default:    sel_o = REG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_main_cnt.sv
module tmr_main_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;

  // software write takes priority over a tick in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (wr_lo_i)       cnt_q[HALF-1:0] <= wdata_i[HALF-1:0];
    else if (wr_hi_i)       cnt_q[CNT_W-1:HALF] <= wdata_i[HALF-1:0];
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_sts_reg.sv
module tmr_sts_reg #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           stop_i,
  input  logic [NCH-1:0] set_i,
  input  logic           wr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] sts_o,
  output logic [NCH-1:0] clr_o
);
  logic [NCH-1:0] sts_q, clr_q, clr_d;

  always_comb begin
    clr_d = '0;
    if (stop_i)    clr_d = sts_q;
    else if (wr_i) clr_d = wdata_i & sts_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      clr_q <= '0;
    end else begin
      clr_q <= clr_d;
      if (stop_i) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_d) | (run_i ? set_i : '0);
    end
  end

  assign sts_o = sts_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/tmr_regblk.sv
module tmr_regblk
  import tmr_regblk_pkg::*;
#(
  parameter int unsigned NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic              tick_i,
  input  logic [NCH-1:0]    sts_set_i,
  input  logic [NCH-1:0]    ch_cmp_max_i,
  input  logic [NCH*32-1:0] ch_rdata_i,
  output logic [63:0]       counter_o,
  output logic              enable_o,
  output logic              legacy_o,
  output logic [NCH-1:0]    ch_wr_o,
  output logic [4:0]        ch_off_o,
  output logic [31:0]       ch_wdata_o,
  output logic [NCH-1:0]    sts_clr_o,
  output logic [NCH-1:0]    ch_arm_o,
  output logic [NCH-1:0]    ch_disarm_o
);
  localparam logic [31:0] CAP_LO = cap_low(NCH);

  reg_sel_e       sel;
  logic [4:0]     ch_idx;
  logic           wr, rd;
  logic           cfg_wr, start, stop;
  logic [1:0]     cfg_q;
  logic [NCH-1:0] arm_q, disarm_q, sts;
  logic [31:0]    ch_rd, rd_data;
  logic           rsp_valid_q;
  logic [31:0]    rdata_q;

  tmr_addr_dec #(.NCH(NCH)) u_dec (
    .addr_i   (req_addr_i),
    .sel_o    (sel),
    .ch_idx_o (ch_idx)
  );

  assign wr     = req_valid_i && req_write_i;
  assign rd     = req_valid_i && !req_write_i;
  assign cfg_wr = wr && (sel == REG_CFG);
  assign start  = cfg_wr && req_wdata_i[0] && !cfg_q[0];
  assign stop   = cfg_wr && !req_wdata_i[0] && cfg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= req_wdata_i[1:0];
      arm_q    <= start ? ~ch_cmp_max_i : '0;
      disarm_q <= stop ? '1 : '0;
    end
  end

  tmr_main_cnt #(.CNT_W(64)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (cfg_q[0]),
    .tick_i  (tick_i),
    .wr_lo_i (wr && (sel == REG_CNT_LO)),
    .wr_hi_i (wr && (sel == REG_CNT_HI)),
    .wdata_i (req_wdata_i),
    .cnt_o   (counter_o)
  );

  tmr_sts_reg #(.NCH(NCH)) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (cfg_q[0]),
    .stop_i  (stop),
    .set_i   (sts_set_i),
    .wr_i    (wr && (sel == REG_STS)),
    .wdata_i (req_wdata_i[NCH-1:0]),
    .sts_o   (sts),
    .clr_o   (sts_clr_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chwr
    assign ch_wr_o[i] = wr && (sel == REG_CHAN) && (ch_idx == 5'(i));
  end

  always_comb begin
    ch_rd = '0;
    for (int i = 0; i < NCH; i++)
      if (ch_idx == 5'(i)) ch_rd = ch_rdata_i[i*32 +: 32];
  end

  always_comb begin
    rd_data = '0;
    unique case (sel)
      REG_CAP_LO: rd_data = CAP_LO;
      REG_CAP_HI: rd_data = PERIOD_FS;
      REG_CFG:    rd_data = {30'b0, cfg_q};
      REG_STS:    rd_data = {{(32-NCH){1'b0}}, sts};
      REG_CNT_LO: rd_data = counter_o[31:0];
      REG_CNT_HI: rd_data = counter_o[63:32];
      REG_CHAN:   rd_data = ch_rd;
      default:    rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rdata_q     <= rd ? rd_data : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign enable_o    = cfg_q[0];
  assign legacy_o    = cfg_q[1];
  assign ch_off_o    = req_addr_i[4:0];
  assign ch_wdata_o  = req_wdata_i;
  assign ch_arm_o    = arm_q;
  assign ch_disarm_o = disarm_q;
endmodule

// File: rtl/tmr_regblk_chk.sv
module tmr_regblk_chk #(
  parameter int unsigned NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_write_i,
  input logic           tick_i,
  input logic [NCH-1:0] ch_cmp_max_i,
  input logic [63:0]    counter_o,
  input logic           enable_o,
  input logic           rsp_valid_o,
  input logic [NCH-1:0] ch_wr_o,
  input logic [NCH-1:0] ch_arm_o,
  input logic [NCH-1:0] ch_disarm_o
);
  p_rsp_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_cnt_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && tick_i && !(req_valid_i && req_write_i)) |=> counter_o == $past(counter_o) + 64'd1);
  p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_o && !(req_valid_i && req_write_i)) |=> $stable(counter_o));
  p_arm_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_o) |-> ch_arm_o == ~$past(ch_cmp_max_i));
  p_arm_only_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_arm_o) |-> $rose(enable_o));
  p_disarm_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enable_o) |-> (&ch_disarm_o));
  p_wr_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));
  p_wr_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_wr_o) |-> (req_valid_i && req_write_i));
endmodule

bind tmr_regblk tmr_regblk_chk #(.NCH(NCH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .tick_i       (tick_i),
  .ch_cmp_max_i (ch_cmp_max_i),
  .counter_o    (counter_o),
  .enable_o     (enable_o),
  .rsp_valid_o  (rsp_valid_o),
  .ch_wr_o      (ch_wr_o),
  .ch_arm_o     (ch_arm_o),
  .ch_disarm_o  (ch_disarm_o)
);

// File: tb/tmr_regblk_test.sv
module tmr_regblk_test;
  localparam int unsigned NCH = 3;
  localparam logic [31:0] PFS = 32'd10_000_000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [9:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic tick_i = 1'b0;
  logic [NCH-1:0] sts_set_i = '0, ch_cmp_max_i = '0;
  logic [NCH*32-1:0] ch_rdata_i;
  logic [63:0] counter_o;
  logic enable_o, legacy_o;
  logic [NCH-1:0] ch_wr_o, sts_clr_o, ch_arm_o, ch_disarm_o;
  logic [4:0] ch_off_o;
  logic [31:0] ch_wdata_o;

  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  for (genvar i = 0; i < NCH; i++) begin : g_chd
    assign ch_rdata_i[i*32 +: 32] = 32'h5A00_0000 | (32'(i) << 16) | {27'b0, ch_off_o};
  end

  tmr_regblk #(.NCH(NCH), .PERIOD_FS(PFS)) uut (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  logic [NCH-1:0] wr_seen;
  logic [4:0] off_seen;
  logic [31:0] wd_seen;

  task automatic wr(logic [9:0] a, logic [31:0] d);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    #1;
    wr_seen = ch_wr_o; off_seen = ch_off_o; wd_seen = ch_wdata_o;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R1 rsp_valid", 64'(rsp_valid_o), 64'd1);
    d = rsp_rdata_o;
  endtask

  function automatic logic [31:0] model(logic [9:0] a, logic [1:0] cfg, logic [NCH-1:0] sts, logic [63:0] cnt);
    int idx;
    if (a[1:0] != 0) return 0;
    if (a >= 10'h100) begin
      idx = (int'(a) - 'h100) / 'h20;
      return (idx < int'(NCH)) ? (32'h5A00_0000 | (32'(idx) << 16) | 32'(a[4:0])) : 32'h0;
    end
    case (a)
      10'h000: return 32'h8086_A001 | (32'(NCH - 1) << 8);
      10'h004: return PFS;
      10'h010: return {30'b0, cfg};
      10'h020: return {29'b0, sts};
      10'h0F0: return cnt[31:0];
      10'h0F4: return cnt[63:32];
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] exp_cnt;
    int n;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 counter", counter_o, 0);
    chk("R12 enable", 64'(enable_o), 0);
    chk("R12 legacy", 64'(legacy_o), 0);
    chk("R12 rsp_valid", 64'(rsp_valid_o), 0);
    chk("R12 pulses", 64'({ch_arm_o, ch_disarm_o, sts_clr_o}), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 idle rsp", 64'(rsp_valid_o), 0);

    // R2 capability, writes ignored
    rd(10'h000, d); chk("R2 cap lo", d, 32'h8086_A201);
    rd(10'h004, d); chk("R2 period", d, PFS);
    wr(10'h000, 32'h0); wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h000, d); chk("R2 cap lo after write", d, 32'h8086_A201);
    rd(10'h004, d); chk("R2 period after write", d, PFS);

    // R3 config mask
    wr(10'h010, 32'hFFFF_FFFC); rd(10'h010, d); chk("R3 masked bits", d, 0);
    wr(10'h010, 32'h2); chk("R3 legacy_o", 64'(legacy_o), 1);
    chk("R3 enable_o stays low", 64'(enable_o), 0);
    rd(10'h010, d); chk("R3 cfg read", d, 2);
    wr(10'h014, 32'hFFFF_FFFF); rd(10'h014, d); chk("R3 cfg high", d, 0);
    wr(10'h010, 32'h0);

    // R5 counter writes and hold while stopped
    wr(10'h0F0, 32'hFFFF_FFFF); wr(10'h0F4, 32'h1);
    tick_i = 1; repeat (10) @(negedge clk_i); tick_i = 0;
    rd(10'h0F0, d); chk("R5 hold lo", d, 32'hFFFF_FFFF);
    rd(10'h0F4, d); chk("R5 hold hi", d, 32'h1);

    // R10/R11 full read sweep
    for (int w = 0; w < 256; w++) begin
      rd(10'(w * 4), d);
      chk($sformatf("R10/R11 read %0h", w * 4), d, model(10'(w * 4), 2'b00, '0, 64'h1_FFFF_FFFF));
    end
    for (int u = 1; u < 4; u++) begin
      rd(10'(10'h010 + u), d); chk("R11 unaligned read", d, 0);
    end
    wr(10'h011, 32'h3); chk("R11 unaligned write", 64'({legacy_o, enable_o}), 0);
    wr(10'h0F8, 32'h5); rd(10'h0F0, d); chk("R11 undefined write", d, 32'hFFFF_FFFF);

    // R10 write strobes over all slots
    for (int s = 0; s < 24; s++) begin
      wr(10'(10'h100 + s * 32 + 8), 32'hC0DE_0000 + 32'(s));
      chk($sformatf("R10 strobe slot %0d", s), 64'(wr_seen), (s < int'(NCH)) ? 64'(1 << s) : 64'd0);
      chk("R10 offset", 64'(off_seen), 8);
      chk("R10 wdata", 64'(wd_seen), 64'(32'hC0DE_0000 + 32'(s)));
    end

    // R8 arm on rising enable
    ch_cmp_max_i = 3'b010;
    wr(10'h010, 32'h1);
    chk("R8 arm mask", 64'(ch_arm_o), 3'b101);
    chk("R8 enable_o", 64'(enable_o), 1);
    @(negedge clk_i);
    chk("R8 arm one cycle", 64'(ch_arm_o), 0);

    // R4 counting with tick pattern and carry
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tick_i = (k % 3) != 0; if (tick_i) n++;
      @(negedge clk_i);
    end
    tick_i = 0;
    exp_cnt = 64'h1_FFFF_FFFF + 64'(n);
    rd(10'h0F0, d); chk("R4 count lo", d, exp_cnt[31:0]);
    rd(10'h0F4, d); chk("R4 count hi", d, exp_cnt[63:32]);
    tick_i = 1; wr(10'h0F0, 32'h10); tick_i = 0;
    rd(10'h0F0, d); chk("R5 write wins", d, 32'h10);

    // R6/R7 status
    sts_set_i = 3'b011; @(negedge clk_i); sts_set_i = 0;
    rd(10'h020, d); chk("R6 status set", d, 3);
    wr(10'h020, 32'h6); chk("R7 clr strobe", 64'(sts_clr_o), 3'b010);
    rd(10'h020, d); chk("R7 status after clear", d, 1);
    wr(10'h020, 32'h0); chk("R7 no strobe", 64'(sts_clr_o), 0);
    rd(10'h020, d); chk("R7 status kept", d, 1);

    // R9 disable
    wr(10'h010, 32'h0);
    chk("R9 disarm", 64'(ch_disarm_o), 3'b111);
    chk("R9 clr on stop", 64'(sts_clr_o), 3'b001);
    chk("R9 enable_o", 64'(enable_o), 0);
    rd(10'h020, d); chk("R9 status cleared", d, 0);
    chk("R9 disarm one cycle", 64'(ch_disarm_o), 0);

    // R6 ignored while stopped
    sts_set_i = 3'b111; @(negedge clk_i); sts_set_i = 0;
    rd(10'h020, d); chk("R6 set ignored stopped", d, 0);

    // R5 freeze then resume
    tick_i = 1; repeat (7) @(negedge clk_i); tick_i = 0;
    rd(10'h0F0, d); chk("R5 frozen", d, 32'h10);
    ch_cmp_max_i = 3'b111;
    wr(10'h010, 32'h1); chk("R8 no arm all max", 64'(ch_arm_o), 0);
    tick_i = 1; repeat (4) @(negedge clk_i); tick_i = 0;
    wr(10'h010, 32'h0);
    rd(10'h0F0, d); chk("R5 resumed", d, 32'h14);
    rd(10'h0F4, d); chk("R5 resumed hi", d, exp_cnt[63:32]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule